// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers the interrupt sources of a network controller into one global status word and drives a single level-sensitive interrupt line. Single-cycle event pulses from the controller set sticky bits. Three per-direction groups (transmit, receive, control) keep their own sticky status words and their own mask words. Whenever a group has an unmasked bit set, a summary bit appears in the global status. The interrupt line is the registered OR of every global bit whose mask bit is clear.

Software reaches the unit over a plain address/data/strobe register port. Reading the global status word returns its contents and clears the sticky bits. A separate write-one-to-clear alias clears bits without a read. Reading a group status word clears that group. The control group is the exception: it keeps its pause-time pointer field. The readout of the global word also carries the controller's current transmit-completion index in its top field. This lets one read return both the cause and the progress of transmission.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the global mask reads 0x0FFFFFFF. The global status, the three group status words and the pause pointer are 0. The three group masks are all ones (0xFFFF). `irq` and `reg_rdata` are 0.
- R2: One cycle after any change of state, `irq` is 1 exactly when some bit of the global view is 1 while its global mask bit is 0. The view is the sticky bits plus the summary bits. Field bits [31:19] never take part.
- R3: A read of address 0 (global status) returns the view and clears every sticky global bit.
- R4: In every readout of addresses 0 and 2, bits [31:19] hold `tx_done_idx` as sampled in the strobe cycle. Bits 8, 9 and 10 hold the transmit, receive and control summaries.
- R5: Address 2 is the clear alias. A write clears each sticky global bit whose written bit is 1. A read returns the same value as address 0 but clears nothing.
- R6: A read of address 3 (transmit group status) or address 4 (receive group status) returns the word zero-extended and then clears it.
- R7: Address 5 reads as {pause pointer[31:16], control events[15:0]}. Reading it clears the event half only. `ptr_ld` loads `ptr_val` into the pointer.
- R8: Group mask words sit at addresses 6, 7 and 8, and a mask bit of 1 disables its source. A summary bit (8, 9 or 10) is 1 while its group has a status bit set whose mask bit is 0. Reading the global status does not clear a summary bit.
- R9: When a clearing read or a clear write meets a new event for the same bit in one cycle, the bit ends up set.
- R10: Bits 8 to 10 and 19 to 31 of `glb_evt` are ignored. Writes to addresses 0, 3, 4 and 5 have no effect. Reads of addresses 9 to 15 return 0.
- R11: Address 1 holds the global mask, which can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, held between reads |
| glb_evt | input | 32 | Global event pulses |
| tx_evt | input | SUB_W | Transmit group event pulses |
| rx_evt | input | SUB_W | Receive group event pulses |
| ctl_evt | input | SUB_W | Control group event pulses |
| ptr_ld | input | 1 | Load strobe for the pause pointer |
| ptr_val | input | 32-SUB_W | Pause pointer value |
| tx_done_idx | input | IDX_W | Current transmit-completion index |
| irq | output | 1 | Level interrupt request |

## Verification
Timing, counted from the clock edge that samples a stimulus:
- A read strobe puts its data on `reg_rdata` at that same edge. The bench therefore checks the data at the next falling edge, after the strobe has dropped.
- A register write, an event pulse or a clear updates the stored state at that edge.
- `irq` follows one edge later. Every direct check of `irq` waits one extra falling edge after the stimulus cycle.

A behavioural model in the bench applies these same latencies each cycle and is compared with `irq` and `reg_rdata` at every falling edge. Same-cycle collisions of a clear and an event are driven in one strobe cycle and read back afterwards.

// File: rtl/irq_pkg.sv
// Shared constants and the register address map of the interrupt status unit.
package irq_pkg;
    localparam int DATA_W  = 32;
    localparam int SUM_TX  = 8;
    localparam int SUM_RX  = 9;
    localparam int SUM_CTL = 10;
    localparam int N_GRP   = 3;

    typedef enum logic [3:0] {
        RA_GSTAT  = 4'd0,
        RA_GMASK  = 4'd1,
        RA_GCLR   = 4'd2,
        RA_TXST   = 4'd3,
        RA_RXST   = 4'd4,
        RA_CTLST  = 4'd5,
        RA_TXMSK  = 4'd6,
        RA_RXMSK  = 4'd7,
        RA_CTLMSK = 4'd8
    } reg_sel_e;

    // Bits of the global word that hold the spliced transmit index.
    function automatic logic [DATA_W-1:0] field_bits(input int idx_w);
        return {DATA_W{1'b1}} << (DATA_W - idx_w);
    endfunction

    // Bits of the global word that hold summaries.
    function automatic logic [DATA_W-1:0] sum_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        m[SUM_TX]  = 1'b1;
        m[SUM_RX]  = 1'b1;
        m[SUM_CTL] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_sub_group.sv
// One per-direction status group: sticky event bits, a mask word and a
// summary hit. Assumes event inputs are one-cycle pulses; a set event in the
// same cycle as a clearing read survives the clear.
module irq_sub_group #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q,
    output logic         hit
);
    // Sticky status: clear on read, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~{W{rd_clr}}) | evt;
        end
    end

    // Mask word: all sources disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_wd;
        end
    end

    // Summary: any enabled source pending.
    always_comb begin
        hit = |(stat_q & ~mask_q);
    end
endmodule

// File: rtl/irq_glob_core.sv
// Global status word, global mask and registered interrupt line. Summary
// bits are live inputs, not stored; the index field is spliced only into
// the readout view. Assumes the summary and field positions do not overlap.
module irq_glob_core
    import irq_pkg::*;
#(
    parameter int                IDX_W    = 13,
    parameter logic [DATA_W-1:0] MASK_RST = 32'h0FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_in,
    input  logic [N_GRP-1:0]  sum_in,
    input  logic [IDX_W-1:0]  tx_idx,
    input  logic              rd_clr,
    input  logic              wclr_we,
    input  logic [DATA_W-1:0] wclr_val,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wd,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] evt_kept,
    output logic [DATA_W-1:0] view,
    output logic              irq
);
    localparam int                FIELD_LSB = DATA_W - IDX_W;
    localparam logic [DATA_W-1:0] FIELD     = field_bits(IDX_W);
    localparam logic [DATA_W-1:0] KEEP      = ~(FIELD | sum_bits());

    logic [DATA_W-1:0] live;
    logic [DATA_W-1:0] clr_vec;

    // Drop event bits that land on summary or field positions.
    always_comb begin
        evt_kept = evt_in & KEEP;
    end

    // Sticky bits joined with the live summaries.
    always_comb begin
        live = stat_q;
        live[SUM_TX]  = sum_in[0];
        live[SUM_RX]  = sum_in[1];
        live[SUM_CTL] = sum_in[2];
    end

    // Readout with the transmit index placed in the top field.
    always_comb begin
        view = (live & ~FIELD) | (DATA_W'(tx_idx) << FIELD_LSB);
    end

    // Bits to clear this cycle from a status read or the clear alias.
    always_comb begin
        clr_vec = ({DATA_W{rd_clr}}) | (wclr_we ? wclr_val : '0);
    end

    // Sticky status: clear first, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | evt_kept;
        end
    end

    // Global mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (mask_we) begin
            mask_q <= mask_wd;
        end
    end

    // Registered interrupt line from the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(live & ~mask_q & ~FIELD);
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit: decodes the register port, holds the
// pause pointer, and ties the three groups to the global core. Assumes at
// most one register access per strobe cycle per address.
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int                IDX_W     = 13,
    parameter int                SUB_W     = 16,
    parameter logic [DATA_W-1:0] GMASK_RST = 32'h0FFF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [31:0]         glb_evt,
    input  logic [SUB_W-1:0]    tx_evt,
    input  logic [SUB_W-1:0]    rx_evt,
    input  logic [SUB_W-1:0]    ctl_evt,
    input  logic                ptr_ld,
    input  logic [31-SUB_W:0]   ptr_val,
    input  logic [IDX_W-1:0]    tx_done_idx,
    output logic                irq
);
    localparam int PTR_W = DATA_W - SUB_W;

    reg_sel_e          sel;
    logic [SUB_W-1:0]  grp_evt  [N_GRP];
    logic [SUB_W-1:0]  grp_stat [N_GRP];
    logic [SUB_W-1:0]  grp_mask [N_GRP];
    logic [N_GRP-1:0]  grp_hit;
    logic [PTR_W-1:0]  ctl_ptr;
    logic [DATA_W-1:0] g_stat;
    logic [DATA_W-1:0] g_mask;
    logic [DATA_W-1:0] g_evt_kept;
    logic [DATA_W-1:0] g_view;
    logic [DATA_W-1:0] rd_mux;
    logic              g_rd_clr;
    logic              g_wclr_we;
    logic              g_mask_we;

    // Decode the register address.
    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        g_rd_clr  = reg_rd && (sel == RA_GSTAT);
        g_wclr_we = reg_wr && (sel == RA_GCLR);
        g_mask_we = reg_wr && (sel == RA_GMASK);
    end

    // Route event inputs into the group array.
    always_comb begin
        grp_evt[0] = tx_evt;
        grp_evt[1] = rx_evt;
        grp_evt[2] = ctl_evt;
    end

    // Group instances: status at address 3+g, mask at address 6+g.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam logic [3:0] ST_A = 4'(int'(RA_TXST) + g);
        localparam logic [3:0] MK_A = 4'(int'(RA_TXMSK) + g);
        irq_sub_group #(.W(SUB_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (grp_evt[g]),
            .rd_clr  (reg_rd && (reg_addr == ST_A)),
            .mask_we (reg_wr && (reg_addr == MK_A)),
            .mask_wd (reg_wdata[SUB_W-1:0]),
            .stat_q  (grp_stat[g]),
            .mask_q  (grp_mask[g]),
            .hit     (grp_hit[g])
        );
    end

    // Pause pointer of the control group, kept across clearing reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_ptr <= '0;
        end else if (ptr_ld) begin
            ctl_ptr <= ptr_val;
        end
    end

    irq_glob_core #(.IDX_W(IDX_W), .MASK_RST(GMASK_RST)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (glb_evt),
        .sum_in   (grp_hit),
        .tx_idx   (tx_done_idx),
        .rd_clr   (g_rd_clr),
        .wclr_we  (g_wclr_we),
        .wclr_val (reg_wdata),
        .mask_we  (g_mask_we),
        .mask_wd  (reg_wdata),
        .stat_q   (g_stat),
        .mask_q   (g_mask),
        .evt_kept (g_evt_kept),
        .view     (g_view),
        .irq      (irq)
    );

    // Read multiplexer over the current register values.
    always_comb begin
        unique case (sel)
            RA_GSTAT, RA_GCLR: rd_mux = g_view;
            RA_GMASK:          rd_mux = g_mask;
            RA_TXST:           rd_mux = DATA_W'(grp_stat[0]);
            RA_RXST:           rd_mux = DATA_W'(grp_stat[1]);
            RA_CTLST:          rd_mux = {ctl_ptr, grp_stat[2]};
            RA_TXMSK:          rd_mux = DATA_W'(grp_mask[0]);
            RA_RXMSK:          rd_mux = DATA_W'(grp_mask[1]);
            RA_CTLMSK:         rd_mux = DATA_W'(grp_mask[2]);
            default:           rd_mux = '0;
        endcase
    end

    // Registered read data, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_status_chk.sv
// Property checker for the interrupt status unit, attached by bind.
module irq_status_chk #(
    parameter int IDX_W = 13,
    parameter int SUB_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [SUB_W-1:0] tx_evt,
    input logic             ptr_ld,
    input logic [31:0]      g_stat,
    input logic [31:0]      g_mask,
    input logic [31:0]      g_evt_kept,
    input logic [31:0]      g_view,
    input logic [SUB_W-1:0] tx_stat,
    input logic [SUB_W-1:0] tx_mask,
    input logic [31-SUB_W:0] ctl_ptr,
    input logic             irq
);
    localparam logic [31:0] FIELD = {32{1'b1}} << (32 - IDX_W);

    p_irq_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(g_view & ~g_mask & ~FIELD))));

    p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd && reg_addr == 4'd0)) |-> (g_stat == $past(g_evt_kept)));

    p_tx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd && reg_addr == 4'd3)) |-> (tx_stat == $past(tx_evt)));

    p_ptr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ptr_ld)) |-> $stable(ctl_ptr));

    p_tx_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g_view[8] == (|(tx_stat & ~tx_mask)));

    p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((g_stat & $past(g_evt_kept)) == $past(g_evt_kept)));
endmodule

bind irq_status_unit irq_status_chk #(.IDX_W(IDX_W), .SUB_W(SUB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .tx_evt     (tx_evt),
    .ptr_ld     (ptr_ld),
    .g_stat     (g_stat),
    .g_mask     (g_mask),
    .g_evt_kept (g_evt_kept),
    .g_view     (g_view),
    .tx_stat    (grp_stat[0]),
    .tx_mask    (grp_mask[0]),
    .ctl_ptr    (ctl_ptr),
    .irq        (irq)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] glb_evt = '0;
    logic [15:0] tx_evt = '0;
    logic [15:0] rx_evt = '0;
    logic [15:0] ctl_evt = '0;
    logic        ptr_ld = 1'b0;
    logic [15:0] ptr_val = '0;
    logic [12:0] tx_done_idx = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glb_evt(glb_evt), .tx_evt(tx_evt), .rx_evt(rx_evt), .ctl_evt(ctl_evt),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .tx_done_idx(tx_done_idx), .irq(irq)
    );

    // Behavioural reference model.
    localparam logic [31:0] FLD  = 32'hFFF8_0000;
    localparam logic [31:0] KEEP = 32'h0007_F8FF;
    logic [31:0] m_g, m_gm, m_rd;
    logic [15:0] m_st [3];
    logic [15:0] m_mk [3];
    logic [15:0] m_ptr;
    logic        m_irq;

    always @(posedge clk) begin
        logic [31:0] live, rv;
        logic [15:0] ev [3];
        int a;
        started = 1;
        if (!rst_n) begin
            m_g = 0; m_gm = 32'h0FFF_FFFF; m_rd = 0; m_ptr = 0; m_irq = 0;
            for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_mk[i] = 16'hFFFF; end
        end else begin
            live = m_g;
            for (int i = 0; i < 3; i++)
                if ((m_st[i] & ~m_mk[i]) != 0) live[8+i] = 1'b1;
            a = int'(reg_addr);
            rv = 0;
            if (a == 0 || a == 2) rv = live | ({19'd0, tx_done_idx} << 19);
            else if (a == 1) rv = m_gm;
            else if (a >= 3 && a <= 4) rv = {16'd0, m_st[a-3]};
            else if (a == 5) rv = {m_ptr, m_st[2]};
            else if (a >= 6 && a <= 8) rv = {16'd0, m_mk[a-6]};
            ev[0] = tx_evt; ev[1] = rx_evt; ev[2] = ctl_evt;
            m_irq = (live & ~m_gm & ~FLD) != 0;
            if (reg_rd) begin
                m_rd = rv;
                if (a == 0) m_g = 0;
                if (a >= 3 && a <= 5) m_st[a-3] = 0;
            end
            if (reg_wr) begin
                if (a == 1) m_gm = reg_wdata;
                if (a == 2) m_g = m_g & ~reg_wdata;
                if (a >= 6 && a <= 8) m_mk[a-6] = reg_wdata[15:0];
            end
            m_g = m_g | (glb_evt & KEEP);
            for (int i = 0; i < 3; i++) m_st[i] = m_st[i] | ev[i];
            if (ptr_ld) m_ptr = ptr_val;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare with the model on every falling edge (R2 irq, R4 read data).
    always @(negedge clk) begin
        if (started && !done) begin
            check({31'd0, irq}, {31'd0, m_irq}, "R2 model irq");
            check(reg_rdata, m_rd, "R4 model rdata");
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
        check(reg_rdata, exp, tag);
    endtask

    task automatic pulse(input logic [31:0] g, input logic [15:0] t,
                         input logic [15:0] r, input logic [15:0] c);
        @(negedge clk); glb_evt = g; tx_evt = t; rx_evt = r; ctl_evt = c;
        @(negedge clk); glb_evt = 0; tx_evt = 0; rx_evt = 0; ctl_evt = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        check({31'd0, irq}, 0, "R1 irq after reset");
        rd(4'd1, 32'h0FFF_FFFF, "R1 gmask");
        rd(4'd0, 0, "R1 gstat");
        rd(4'd6, 32'h0000_FFFF, "R1 tx mask");
        rd(4'd5, 0, "R1 ctl status");
        wr(4'd1, 0);
        rd(4'd1, 0, "R11 gmask write");
        // R2 event raises irq.
        pulse(32'h1, 0, 0, 0);
        @(negedge clk);
        check({31'd0, irq}, 1, "R2 irq set");
        rd(4'd0, 32'h1, "R3 read value");
        rd(4'd0, 0, "R3 cleared");
        check({31'd0, irq}, 0, "R3 irq dropped");
        // R2 masked source.
        wr(4'd1, 32'h1);
        pulse(32'h1, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        check({31'd0, irq}, 0, "R2 masked");
        rd(4'd0, 32'h1, "R2 masked still latched");
        wr(4'd1, 0);
        // R4 index field.
        tx_done_idx = 13'h1ABC;
        rd(4'd0, 32'hD5E0_0000, "R4 index field");
        @(negedge clk);
        check({31'd0, irq}, 0, "R2 field excluded");
        tx_done_idx = 0;
        // R10 ignored positions, R5 alias.
        pulse(32'hFFFF_FFFF, 0, 0, 0);
        rd(4'd2, 32'h0007_F8FF, "R10 ignored event bits");
        rd(4'd2, 32'h0007_F8FF, "R5 alias read keeps");
        wr(4'd2, 32'h0000_000F);
        rd(4'd0, 32'h0007_F8F0, "R5 write clear");
        rd(4'd0, 0, "R3 cleared again");
        // R6 group read clears.
        pulse(0, 16'h0005, 16'h8001, 0);
        rd(4'd3, 32'h5, "R6 tx read");
        rd(4'd3, 0, "R6 tx cleared");
        rd(4'd4, 32'h8001, "R6 rx read");
        rd(4'd4, 0, "R6 rx cleared");
        // R8 summaries.
        wr(4'd6, 32'hFFFE);
        pulse(0, 16'h0001, 0, 0);
        rd(4'd0, 32'h100, "R8 tx summary");
        rd(4'd0, 32'h100, "R8 summary survives gstat read");
        @(negedge clk);
        check({31'd0, irq}, 1, "R8 summary irq");
        rd(4'd3, 32'h1, "R6 tx read with summary");
        rd(4'd0, 0, "R8 summary gone");
        wr(4'd7, 32'h7FFF);
        pulse(0, 0, 16'h8000, 0);
        rd(4'd0, 32'h200, "R8 rx summary");
        rd(4'd4, 32'h8000, "R6 rx clear");
        // R7 control group and pointer.
        @(negedge clk); ptr_ld = 1; ptr_val = 16'hBEEF; ctl_evt = 16'h0003;
        @(negedge clk); ptr_ld = 0; ctl_evt = 0;
        rd(4'd5, 32'hBEEF_0003, "R7 ctl read");
        rd(4'd5, 32'hBEEF_0000, "R7 pointer kept");
        wr(4'd8, 32'hFFFD);
        pulse(0, 0, 0, 16'h0002);
        rd(4'd0, 32'h400, "R8 ctl summary");
        rd(4'd5, 32'hBEEF_0002, "R7 ctl read again");
        rd(4'd0, 0, "R8 ctl summary gone");
        // R9 same-cycle clear and event.
        @(negedge clk); reg_addr = 4'd0; reg_rd = 1; glb_evt = 32'h2;
        @(negedge clk); reg_rd = 0; glb_evt = 0;
        check(reg_rdata, 0, "R9 old value read");
        rd(4'd0, 32'h2, "R9 event kept over read clear");
        @(negedge clk); reg_addr = 4'd3; reg_rd = 1; tx_evt = 16'h4;
        @(negedge clk); reg_rd = 0; tx_evt = 0;
        rd(4'd3, 32'h4, "R9 tx event kept");
        @(negedge clk); reg_addr = 4'd2; reg_wdata = 32'h8; reg_wr = 1; glb_evt = 32'h8;
        @(negedge clk); reg_wr = 0; glb_evt = 0;
        rd(4'd0, 32'h8, "R9 event kept over write clear");
        // R10 ignored writes and unmapped reads.
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd0, 0, "R10 gstat write ignored");
        rd(4'd3, 0, "R10 tx status write ignored");
        rd(4'd5, 32'hBEEF_0000, "R10 ctl status write ignored");
        rd(4'd12, 0, "R10 unmapped read");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule